// File: doc/BRIEF.md
# Dual-Channel DAC Serial Loader

This block writes a pair of 12-bit output codes into an external two-channel serial DAC. One SPI transaction carries both codes. When the update strobe is seen while the block is idle, it captures both codes. It then drives a 24-bit frame, most significant bit first, on a master SCK/MOSI pair while a 2-bit select code steers an external decoder to the DAC. The DAC latches both channels together when the select is released, so the two analog outputs always change in the same instant.

The two codes share three bytes. The first byte is the upper eight bits of channel A. The middle byte holds the low nibble of A followed by the high nibble of B. The last byte is the low eight bits of B. Code 0x000 stands for 0 V and 0xFFF for 4.095 V, one millivolt per step.

After each frame the select stays released for at least one full SCK period before another frame can start. `busy` covers that quiet time. `done` marks the cycle in which the select is released.

Top module: `dac_pair_loader`

## Requirements
- R1: After reset, and whenever `busy` is low, `sel_code` is 2'b11 (no device selected), `sck` is 0 and `done` is 0.
- R2: When `load_req` is high on a clock edge while `busy` is low, `sel_code` becomes 2'b01 (bit 1 low, bit 0 high: the DAC) and `busy` becomes 1 from the next cycle.
- R3: The frame is 24 bits, most significant bit first. Byte 0 is `code_a[11:4]`. Byte 1 is `{code_a[3:0], code_b[11:8]}`. Byte 2 is `code_b[7:0]`.
- R4: `sck` idles low and each SCK half period lasts `HALF_DIV` clock cycles. `mosi` changes only at the falling edge of `sck`, so it is stable on every rising edge, where the DAC samples it.
- R5: `sel_code` stays 2'b01 without a break for exactly 24 SCK periods (24 rising edges). `sck` never toggles while the DAC is not selected.
- R6: The select returns to 2'b11 on the clock edge of the 24th falling SCK edge. `done` is high for exactly that one cycle.
- R7: Both codes are captured at the accepted strobe. Changes on `code_a` and `code_b` during a frame do not alter the frame being sent.
- R8: A strobe that arrives while `busy` is high, during the shift or the quiet time, is ignored and starts no frame.
- R9: After the select is released, `busy` stays high for 2*`HALF_DIV` cycles (one SCK period). If the strobe is held high continuously, the select stays at 2'b11 for exactly 2*`HALF_DIV`+1 cycles between frames.
- R10: The boundary codes 0x000 and 0xFFF produce frames of all-zero bits and all-one bits in their positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| code_a | input | 12 | Output code for channel A |
| code_b | input | 12 | Output code for channel B |
| load_req | input | 1 | Update strobe; accepted only while idle |
| sck | output | 1 | SPI serial clock, idles low |
| mosi | output | 1 | SPI data out, MSB first |
| sel_code | output | 2 | Select code for the external decoder: 2'b01 DAC, 2'b11 none |
| busy | output | 1 | High from frame start to the end of the quiet time |
| done | output | 1 | One-cycle pulse when the select is released |

## Verification
The assertions check these rules on every cycle:
- The idle select code and the low SCK while idle.
- The start of a frame on an accepted strobe.
- MOSI holding still while SCK is high.
- SCK staying quiet whenever the DAC is not selected.
- `done` being a single cycle and coinciding with deselect.
- No reselect during the quiet time.

Some properties can only be shown by the bench's scenarios, which compare every output against a behavioural model on every clock:
- The exact byte packing with the straddling nibbles.
- The boundary codes.
- Immunity to input changes mid-frame.
- Rejection of strobes while busy.
- The exact length of the gap between back-to-back frames.

// File: rtl/dpl_pkg.sv
package dpl_pkg;
  parameter int unsigned CODE_W = 12;
  localparam int unsigned FRAME_BITS = 2 * CODE_W;

  localparam logic [1:0] SEL_DAC  = 2'b01;
  localparam logic [1:0] SEL_NONE = 2'b11;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_QUIET} ld_state_t;

  // Channel A ahead of channel B, MSB first: the middle byte straddles both.
  function automatic logic [FRAME_BITS-1:0] pack_pair(
    input logic [CODE_W-1:0] a, input logic [CODE_W-1:0] b);
    logic [FRAME_BITS-1:0] f;
    f = '0;
    for (int i = 0; i < int'(CODE_W); i++) begin
      f[FRAME_BITS-1-i] = a[CODE_W-1-i];
      f[CODE_W-1-i]     = b[CODE_W-1-i];
    end
    return f;
  endfunction
endpackage

// File: rtl/dpl_tick_gen.sv
module dpl_tick_gen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dpl_shreg.sv
module dpl_shreg #(
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             shift,
  output logic             msb
);
  logic [WIDTH-1:0] hold_q;

  assign msb = hold_q[WIDTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= '0;
    else if (load)  hold_q <= load_val;
    else if (shift) hold_q <= {hold_q[WIDTH-2:0], 1'b0};
  end
endmodule

// File: rtl/dpl_ctrl.sv
module dpl_ctrl
  import dpl_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned NBITS    = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_req,
  input  logic tick,
  output logic run,
  output logic frame_start,
  output logic bit_fall,
  output logic frame_end,
  output logic sck,
  output logic sel_active,
  output logic busy,
  output logic done
);
  localparam int unsigned BCW = $clog2(NBITS);
  localparam int unsigned GCW = $clog2(2 * HALF_DIV) + 1;
  localparam logic [BCW-1:0] BIT_LAST = BCW'(NBITS - 1);
  localparam logic [GCW-1:0] GAP_LAST = GCW'(2 * HALF_DIV - 1);

  ld_state_t      state_q;
  logic           sck_q;
  logic           done_q;
  logic [BCW-1:0] bit_q;
  logic [GCW-1:0] gap_q;

  assign run         = (state_q == ST_SHIFT);
  assign frame_start = (state_q == ST_IDLE) && load_req;
  assign bit_fall    = run && tick && sck_q;
  assign frame_end   = bit_fall && (bit_q == BIT_LAST);

  assign sck        = sck_q;
  assign sel_active = run;
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b0;
      done_q  <= 1'b0;
      bit_q   <= '0;
      gap_q   <= '0;
    end else begin
      done_q <= frame_end;
      unique case (state_q)
        ST_IDLE: begin
          if (frame_start) begin
            state_q <= ST_SHIFT;
            sck_q   <= 1'b0;
            bit_q   <= '0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sck_q <= ~sck_q;
            if (frame_end) begin
              state_q <= ST_QUIET;
              gap_q   <= '0;
            end else if (bit_fall) begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_QUIET: begin
          if (gap_q == GAP_LAST) state_q <= ST_IDLE;
          else                   gap_q   <= gap_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_pair_loader.sv
module dac_pair_loader
  import dpl_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  input  logic              load_req,
  output logic              sck,
  output logic              mosi,
  output logic [1:0]        sel_code,
  output logic              busy,
  output logic              done
);
  logic                  run;
  logic                  tick;
  logic                  frame_start;
  logic                  bit_fall;
  logic                  frame_end;
  logic                  sel_active;
  logic [FRAME_BITS-1:0] packed_frame;

  assign packed_frame = pack_pair(code_a, code_b);
  assign sel_code     = sel_active ? SEL_DAC : SEL_NONE;

  dpl_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  dpl_ctrl #(.HALF_DIV(HALF_DIV), .NBITS(FRAME_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .tick(tick),
    .run(run), .frame_start(frame_start), .bit_fall(bit_fall),
    .frame_end(frame_end), .sck(sck), .sel_active(sel_active),
    .busy(busy), .done(done)
  );

  dpl_shreg #(.WIDTH(FRAME_BITS)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(frame_start), .load_val(packed_frame),
    .shift(bit_fall), .msb(mosi)
  );
endmodule

// File: rtl/dpl_checker.sv
module dpl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       load_req,
  input logic       sck,
  input logic       mosi,
  input logic [1:0] sel_code,
  input logic       busy,
  input logic       done,
  input logic       bit_fall,
  input logic       frame_start
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sel_code == 2'b11 && !sck && !done));

  p_start_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !busy) |=> (sel_code == 2'b01 && busy));

  p_start_evt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !busy);

  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  p_fall_drops_sck_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_fall |=> !sck);

  p_sck_only_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_code != 2'b01) |-> !sck);

  p_done_at_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sel_code == 2'b11 && $past(sel_code) == 2'b01));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_reselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sel_code == 2'b11) |=> (sel_code == 2'b11));
endmodule

bind dac_pair_loader dpl_checker u_dpl_checker (
  .clk(clk), .rst_n(rst_n), .load_req(load_req), .sck(sck), .mosi(mosi),
  .sel_code(sel_code), .busy(busy), .done(done), .bit_fall(bit_fall),
  .frame_start(frame_start)
);

// File: tb/tb_dac_pair_loader.sv
module tb_dac_pair_loader;
  localparam int H = 2;
  localparam int FRAME_LEN = 48 * H;
  localparam int END_K = 50 * H;

  logic clk = 0, rst_n = 0;
  logic [11:0] code_a = 0, code_b = 0;
  logic load_req = 0;
  logic sck, mosi, busy, done;
  logic [1:0] sel_code;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dac_pair_loader #(.HALF_DIV(H)) dut (
    .clk(clk), .rst_n(rst_n), .code_a(code_a), .code_b(code_b),
    .load_req(load_req), .sck(sck), .mosi(mosi), .sel_code(sel_code),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: k counts cycles since accepted strobe, -1 idle.
  int k = -1;
  logic [23:0] m_bits;
  int starts = 0;
  always @(posedge clk) begin
    if (!rst_n) k = -1;
    else if (k < 0) begin
      if (load_req) begin
        k = 0;
        for (int i = 0; i < 12; i++) begin
          m_bits[23 - i] = code_a[11 - i];
          m_bits[11 - i] = code_b[11 - i];
        end
        starts++;
      end
    end else begin
      k++;
      if (k == END_K) k = -1;
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [1:0] e_sel; logic e_sck, e_mosi, e_busy, e_done;
      if (k < 0) begin
        e_sel = 2'b11; e_sck = 0; e_mosi = 0; e_busy = 0; e_done = 0;
      end else if (k < FRAME_LEN) begin
        e_sel = 2'b01; e_sck = ((k / H) % 2) == 1;
        e_mosi = m_bits[23 - k / (2 * H)]; e_busy = 1; e_done = 0;
      end else begin
        e_sel = 2'b11; e_sck = 0; e_mosi = 0; e_busy = 1; e_done = (k == FRAME_LEN);
      end
      check(sel_code == e_sel, "R5 sel_code", sel_code, e_sel);
      check(sck == e_sck, "R4 sck", sck, e_sck);
      check(mosi == e_mosi, "R3 mosi", mosi, e_mosi);
      check(busy == e_busy, "R9 busy", busy, e_busy);
      check(done == e_done, "R6 done", done, e_done);
    end
  end

  // Receiver: collects bits on SCK rising edges, yields a word at done.
  logic prev_sck = 0;
  logic [23:0] rx_word;
  int rx_cnt = 0;
  logic [23:0] last_rx;
  int last_cnt = 0;
  int frames_seen = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sck && !prev_sck && sel_code == 2'b01) begin
        rx_word = {rx_word[22:0], mosi};
        rx_cnt++;
      end
      if (done) begin
        last_rx = rx_word; last_cnt = rx_cnt; rx_cnt = 0; frames_seen++;
      end
      prev_sck = sck;
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic send(input logic [11:0] a, input logic [11:0] b);
    @(negedge clk);
    code_a = a; code_b = b; load_req = 1;
    @(negedge clk);
    load_req = 0;
    wait_idle();
  endtask

  task automatic check_bytes(input logic [11:0] a, input logic [11:0] b, input string req);
    logic [7:0] b0, b1, b2;
    b0 = a[11:4]; b1 = {a[3:0], b[11:8]}; b2 = b[7:0];
    check(last_cnt == 24, {req, " bit count (R5)"}, last_cnt, 24);
    check(last_rx[23:16] == b0, {req, " byte0"}, last_rx[23:16], b0);
    check(last_rx[15:8] == b1, {req, " byte1"}, last_rx[15:8], b1);
    check(last_rx[7:0] == b2, {req, " byte2"}, last_rx[7:0], b2);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int fs;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sel_code == 2'b11, "R1 reset sel", sel_code, 2'b11);
    check(sck == 0 && busy == 0 && done == 0, "R1 reset flags", {sck, busy, done}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(sel_code == 2'b11 && !busy, "R1 idle after reset", sel_code, 2'b11);

    // R2/R3: basic frame
    @(negedge clk); code_a = 12'hABC; code_b = 12'h123; load_req = 1;
    @(negedge clk); load_req = 0;
    check(sel_code == 2'b01 && busy, "R2 start", {busy, sel_code}, 3'b101);
    wait_idle();
    check_bytes(12'hABC, 12'h123, "R3");

    // R7 and R8: change inputs and pulse strobe mid-frame and in the quiet time
    fs = frames_seen;
    @(negedge clk); code_a = 12'h5A6; code_b = 12'h9C3; load_req = 1;
    @(negedge clk); load_req = 0;
    repeat (10) @(negedge clk);
    code_a = 12'hFFF; code_b = 12'h000; load_req = 1;
    @(negedge clk); load_req = 0;
    while (!done) @(negedge clk);
    @(negedge clk); load_req = 1;
    @(negedge clk); load_req = 0;
    wait_idle();
    check_bytes(12'h5A6, 12'h9C3, "R7");
    check(frames_seen == fs + 1, "R8 ignored strobes", frames_seen - fs, 1);

    // R10: boundary codes
    send(12'h000, 12'hFFF); check_bytes(12'h000, 12'hFFF, "R10");
    send(12'hFFF, 12'h000); check_bytes(12'hFFF, 12'h000, "R10");
    send(12'hFFF, 12'hFFF);
    check(last_rx == 24'hFFFFFF, "R10 all ones", last_rx, 24'hFFFFFF);
    send(12'h000, 12'h000);
    check(last_rx == 24'h000000, "R10 all zeros", last_rx, 0);

    // R9: strobe held high, measure deselect gap
    begin
      int gap = 0;
      @(negedge clk); code_a = 12'h321; code_b = 12'h654; load_req = 1;
      while (!done) @(negedge clk);
      while (sel_code == 2'b11) begin gap++; @(negedge clk); end
      load_req = 0;
      check(gap == 2 * H + 1, "R9 gap length", gap, 2 * H + 1);
      wait_idle();
      check_bytes(12'h321, 12'h654, "R9 second frame");
    end

    // R3: further patterns
    for (int i = 0; i < 4; i++) begin
      logic [11:0] a, b;
      a = 12'(12'h1F0 * (i + 1) + 12'h00D);
      b = 12'(12'hE07 ^ (12'h111 * i));
      send(a, b);
      check_bytes(a, b, "R3 pattern");
    end

    check(starts == frames_seen, "R6 done per frame", frames_seen, starts);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule